// File: doc/BRIEF.md
# External Interrupt Edge Detector with Polarity and Timer Gating

This block watches one external interrupt pin for a small 4-bit controller. A 4-bit control word, written from and read back to the accumulator bus, sets three things. It picks the active polarity. It picks one-edge or both-edge detection. It decides whether the pin may gate a companion timer. The pin passes through a two-flop synchronizer. The synchronized level is then decoded through the polarity bit into an "active" level. A two-state machine remembers the previous decoded level and flags the selected transitions into a request flag.

Software reads the flag with a test-and-clear strobe. The skip output returns the flag value in the strobe cycle, and the flag is cleared on that edge unless a new edge arrives at the same moment. A separate level output reports the decoded pin level and has no side effect on the flag. The history register keeps running while the control word changes, so a write that flips the decoded level can raise the request flag. Software must clear it afterwards.

State machine `hist_state_t`:
- States: `HIST_INACTIVE` (the previous decoded level was inactive) and `HIST_ACTIVE` (the previous decoded level was active). Reset enters `HIST_ACTIVE`.
- Transitions: `GO_ACTIVE` (INACTIVE to ACTIVE, taken when the decoded level is active) and `GO_INACTIVE` (ACTIVE to INACTIVE, taken when the decoded level is inactive).
- Any other cycle holds the current state.
- `GO_ACTIVE` raises an edge in one-edge mode. Either transition raises an edge in both-edge mode.

Top module: `irq_edge_ctl`

## Requirements
- R1: The control word resets to 0000. A write stores all 4 bits, including bit 3, which has no function, and the readback port shows them from the next cycle.
- R2: When control bit 0 is 0, the timer-control output is 0. When it is 1, the timer-control output equals the level-test output.
- R3: With bit 1 = 0 and bit 2 = 0, a falling pin edge sets the request flag and a rising edge does not.
- R4: With bit 1 = 0 and bit 2 = 1, a rising pin edge sets the request flag and a falling edge does not.
- R5: With bit 1 = 1, both rising and falling edges set the request flag, whatever bit 2 holds.
- R6: The level-test output is 1 for a low pin when bit 2 = 0 and for a high pin when bit 2 = 1. It follows the pin two clock edges after the pin changes, and reading it does not change the flag.
- R7: During a test-and-clear strobe, the skip output shows the flag. If no edge arrives in that cycle, the flag is 0 after the edge.
- R8: An edge detected in the same cycle as a test-and-clear leaves the flag set.
- R9: In one-edge mode, a write that turns the decoded level from inactive to active sets the flag. A write that leaves it active or turns it inactive does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Asynchronous external interrupt pin |
| cfg_wr_i | input | 1 | Load control word from the accumulator |
| cfg_wdata_i | input | 4 | Accumulator value to load |
| cfg_rdata_o | output | 4 | Control word readback to the accumulator |
| tst_clr_i | input | 1 | Test-and-clear strobe for the request flag |
| skip_o | output | 1 | Request flag value seen by the test-and-clear |
| level_o | output | 1 | Decoded pin level for the level test |
| timer_ctl_o | output | 1 | Timer gate enable driven by the pin |

## Verification
The bench targets the edge that lands in the same cycle as a clear. A design that gives the clear priority would lose that event and return no skip on the next test.

It also drives writes that flip polarity over a steady pin. A design whose history register ignores the decoded level would never raise the spurious flag. A design that flags both directions in one-edge mode would flag a write that makes the level inactive.

Both-edge mode is run with each polarity, so a design that lets bit 2 filter edges there misses one direction. Bit 3 is written and read back to catch a register that drops the spare bit.

// File: rtl/irq_edge_pkg.sv
package irq_edge_pkg;

    localparam int CFG_W = 4;

    // Control word bit positions (software-visible encoding)
    localparam int CFG_TMR_EN = 0;
    localparam int CFG_BOTH   = 1;
    localparam int CFG_POL    = 2;
    localparam int CFG_SPARE  = 3;

    // Previous decoded level of the pin
    typedef enum logic {
        HIST_INACTIVE = 1'b0,
        HIST_ACTIVE   = 1'b1
    } hist_state_t;

endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_i;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/irq_cfg_reg.sv
module irq_cfg_reg
    import irq_edge_pkg::*;
#(
    parameter int W = CFG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] cfg_o
);
    logic [W-1:0] cfg_q;

    // Only reset clears the word; retention modes simply hold the clock off.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cfg_q <= '0;
        else if (wr_i) cfg_q <= wdata_i;
    end

    assign cfg_o = cfg_q;
endmodule

// File: rtl/irq_edge_fsm.sv
module irq_edge_fsm
    import irq_edge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dec_i,      // decoded (polarity-adjusted) level
    input  logic both_i,     // both-edge mode
    input  logic tst_clr_i,
    output logic edge_o,
    output logic flag_o
);
    hist_state_t state_q, state_d;
    logic        flag_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= HIST_ACTIVE;
        else        state_q <= state_d;
    end

    // Next state and edge output
    always_comb begin
        state_d = state_q;
        edge_o  = 1'b0;
        unique case (state_q)
            HIST_INACTIVE: begin
                if (dec_i) begin
                    state_d = HIST_ACTIVE;   // GO_ACTIVE
                    edge_o  = 1'b1;
                end
            end
            HIST_ACTIVE: begin
                if (!dec_i) begin
                    state_d = HIST_INACTIVE; // GO_INACTIVE
                    edge_o  = both_i;
                end
            end
        endcase
    end

    // Request flag: set wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         flag_q <= 1'b0;
        else if (edge_o)    flag_q <= 1'b1;
        else if (tst_clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/irq_edge_ctl.sv
module irq_edge_ctl
    import irq_edge_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_i,
    input  logic             cfg_wr_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic [CFG_W-1:0] cfg_rdata_o,
    input  logic             tst_clr_i,
    output logic             skip_o,
    output logic             level_o,
    output logic             timer_ctl_o
);
    logic             pin_sync;
    logic [CFG_W-1:0] cfg;
    logic             dec_level;
    logic             edge_hit;
    logic             flag_q;

    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync)
    );

    irq_cfg_reg #(.W(CFG_W)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (cfg_wr_i),
        .wdata_i (cfg_wdata_i),
        .cfg_o   (cfg)
    );

    // Active level: high pin when polarity bit set, low pin otherwise
    assign dec_level = pin_sync ^ ~cfg[CFG_POL];

    irq_edge_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec_i     (dec_level),
        .both_i    (cfg[CFG_BOTH]),
        .tst_clr_i (tst_clr_i),
        .edge_o    (edge_hit),
        .flag_o    (flag_q)
    );

    assign cfg_rdata_o = cfg;
    assign skip_o      = flag_q;
    assign level_o     = dec_level;
    assign timer_ctl_o = cfg[CFG_TMR_EN] & dec_level;
endmodule

// File: rtl/irq_edge_ctl_chk.sv
module irq_edge_ctl_chk
    import irq_edge_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr_i,
    input logic [CFG_W-1:0] cfg_wdata_i,
    input logic [CFG_W-1:0] cfg_rdata_o,
    input logic             tst_clr_i,
    input logic             edge_hit,
    input logic             flag_q,
    input logic             timer_ctl_o
);
    // R1
    cfg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_i |=> cfg_rdata_o == $past(cfg_wdata_i));

    // R1
    cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> $stable(cfg_rdata_o));

    // R2
    timer_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata_o[CFG_TMR_EN] |-> !timer_ctl_o);

    // R7
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tst_clr_i && !edge_hit) |=> !flag_q);

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_hit |=> flag_q);
endmodule

bind irq_edge_ctl irq_edge_ctl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_i    (cfg_wr_i),
    .cfg_wdata_i (cfg_wdata_i),
    .cfg_rdata_o (cfg_rdata_o),
    .tst_clr_i   (tst_clr_i),
    .edge_hit    (edge_hit),
    .flag_q      (flag_q),
    .timer_ctl_o (timer_ctl_o)
);

// File: tb/irq_edge_ctl_bench.sv
module irq_edge_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin = 1'b0;
    logic       wr = 1'b0;
    logic [3:0] wdata = 4'h0;
    logic [3:0] rdata;
    logic       tst = 1'b0;
    logic       skip;
    logic       level;
    logic       timer;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    int    exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    irq_edge_ctl u_irq_edge_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pin_i       (pin),
        .cfg_wr_i    (wr),
        .cfg_wdata_i (wdata),
        .cfg_rdata_o (rdata),
        .tst_clr_i   (tst),
        .skip_o      (skip),
        .level_o     (level),
        .timer_ctl_o (timer)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: samples skip before the edge consumes the strobe
    always @(posedge clk) begin
        if (rst_n && tst && exp_q.size() > 0) begin
            int    e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e >= 0) check(skip == e[0], t, skip, e);
        end
    end

    task automatic pulse_tst(input int exp, input string tag);
        @(negedge clk); #1;
        tst = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk); #1;
        tst = 1'b0;
    endtask

    task automatic write_cfg(input logic [3:0] v);
        @(negedge clk); #1;
        wr = 1'b1; wdata = v;
        @(negedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk); #1;
        pin = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state
        check(rdata == 4'h0, "R1 reset word", rdata, 0);
        check(level == 1'b1, "R6 low pin pol0", level, 1);
        check(timer == 1'b0, "R2 timer off at reset", timer, 0);
        pulse_tst(0, "R7 no flag at reset");

        // R1 spare bit
        write_cfg(4'b1000);
        check(rdata == 4'b1000, "R1 spare bit readback", rdata, 8);
        write_cfg(4'b1011);
        check(rdata == 4'b1011, "R1 readback", rdata, 11);
        write_cfg(4'b0000);
        pulse_tst(-1, "");

        // R3 falling only
        set_pin(1'b1);
        check(level == 1'b0, "R6 high pin pol0", level, 0);
        pulse_tst(0, "R3 rising ignored");
        set_pin(1'b0);
        pulse_tst(1, "R3 falling sets");
        pulse_tst(0, "R7 cleared after test");

        // R4 rising only
        write_cfg(4'b0100);
        pulse_tst(0, "R9 write to inactive no flag");
        check(level == 1'b0, "R6 low pin pol1", level, 0);
        set_pin(1'b1);
        check(level == 1'b1, "R6 high pin pol1", level, 1);
        pulse_tst(1, "R4 rising sets");
        set_pin(1'b0);
        pulse_tst(0, "R4 falling ignored");

        // R2 timer gating
        write_cfg(4'b0101);
        check(timer == 1'b0, "R2 enabled pin inactive", timer, 0);
        set_pin(1'b1);
        check(timer == 1'b1, "R2 enabled pin active", timer, 1);
        write_cfg(4'b0100);
        check(timer == 1'b0, "R2 disabled pin active", timer, 0);
        pulse_tst(-1, "");

        // R9 spurious flag from polarity writes (pin high)
        write_cfg(4'b0000);
        pulse_tst(0, "R9 decode goes inactive");
        write_cfg(4'b0100);
        pulse_tst(1, "R9 decode goes active");

        // R5 both edges, both polarities
        write_cfg(4'b0010);
        pulse_tst(-1, "");
        set_pin(1'b0);
        pulse_tst(1, "R5 falling pol0");
        set_pin(1'b1);
        pulse_tst(1, "R5 rising pol0");
        write_cfg(4'b0110);
        pulse_tst(-1, "");
        set_pin(1'b0);
        pulse_tst(1, "R5 falling pol1");

        // R8 edge coincident with clear (both-edge mode, pin low)
        pulse_tst(-1, "");
        @(negedge clk); #1;
        pin = 1'b1;
        @(negedge clk);
        pulse_tst(0, "R8 flag before edge");
        pulse_tst(1, "R8 edge kept over clear");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) check(1'b0, "scoreboard drain", exp_q.size(), 0);
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            check(1'b0, "watchdog", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule